// File: doc/BRIEF.md
# Receive Timeout Watchdog

This block supervises one receive session of a radio front end and raises a timeout flag when the expected events of that session do not arrive in time. The session is marked by a level input that is high while the receiver is active. Time is measured in bit periods, delivered as a one-cycle tick by an external bit-rate generator. Both timeout limits are 8-bit values that count in units of 16 bit periods.

The watchdog runs two phases, one after the other. The first phase starts when the session begins and waits for the signal-strength threshold event. The second phase starts at that event and waits for the payload-ready event. A limit of zero turns its phase off. The phase then never times out, but it still waits for its closing event. A timeout flag is raised when either phase expires. The flag stays set until it is cleared by a write-one-to-clear pulse or until the session ends. A controller uses the flag to shut the receiver down and return it to a low-power state.

Top module: `rx_timeout_wdg`

## Requirements
- R1: After reset, timeout_o is 0.
- R2: With start_limit_i = S > 0 and no threshold event, timeout_o rises on the clock edge that registers the 16·S-th bit tick counted after session entry. Ticks are counted from the cycle after the one in which rx_active_i is first seen high.
- R3: A rssi_hit_i pulse while the first phase is pending ends that phase without a timeout. In the same cycle it starts the second phase with a count of zero. A pulse in the session's entry cycle goes straight to the second phase.
- R4: With rssi_limit_i = R > 0, timeout_o rises on the edge that registers the 16·R-th tick counted after the cycle of the threshold event, if payload_rdy_i has not been seen.
- R5: A payload_rdy_i pulse during the second phase ends it. No timeout follows in that session. A payload_rdy_i pulse during the first phase has no effect.
- R6: A limit of 0x00 disables its phase. With S = 0 no timeout occurs before the threshold event. With R = 0 no timeout occurs after it.
- R7: timeout_o stays 1 until timeout_clr_i is seen high on an edge, which clears it. If a timeout fires in the same cycle as a clear, the flag is set.
- R8: When rx_active_i is low, the flag clears on the next edge and all counts return to zero. On re-entry, ticks are counted afresh, with no carry-over from the earlier session.
- R9: A closing event (rssi_hit_i for phase one, payload_rdy_i for phase two) that arrives in the same cycle as the phase's final tick wins, and no timeout fires.
- R10: Only cycles with bit_tick_i high advance the count. Each phase expires at most once per session and only on a ticking cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_active_i | input | 1 | High while a receive session is in progress |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| rssi_hit_i | input | 1 | Signal-strength threshold crossed (pulse) |
| payload_rdy_i | input | 1 | Payload received (pulse) |
| start_limit_i | input | 8 | First-phase limit in units of 16 bit periods, 0 = off |
| rssi_limit_i | input | 8 | Second-phase limit in units of 16 bit periods, 0 = off |
| timeout_clr_i | input | 1 | Write-one-to-clear for the timeout flag |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The assertions check, on every cycle, the rules for the flag's edges. The flag clears once the session ends. It holds until cleared, and a clear with no tick pending takes it low. It can rise only after a ticking cycle within a session, never in the entry cycle, and never while both limits are zero. Exact expiry cycles can only be shown by the bench's scenarios, which compare the flag against a tick-counting model. The same holds for the hand-over from the first phase to the second, payload cancellation, the event-beats-final-tick priority and the fresh restart on re-entry.

// File: rtl/rx_wdg_pkg.sv
package rx_wdg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE         = 2'd0,
        PH_WAIT_RSSI    = 2'd1,
        PH_WAIT_PAYLOAD = 2'd2,
        PH_DONE         = 2'd3
    } wdg_phase_e;

    typedef struct packed {
        wdg_phase_e phase;
        logic       flag;
    } wdg_ctrl_t;

    localparam int unsigned NUM_PHASES = 2;

endpackage

// File: rtl/rx_wdg_prescale.sv
module rx_wdg_prescale #(
    parameter int unsigned PRE_W = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic tick_i,
    output logic wrap_o
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign wrap_o = tick_i && (st_q.cnt == PRE_LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/rx_wdg_phase.sv
module rx_wdg_phase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             unit_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] units;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic [CNT_W:0] units_next;

    always_comb begin
        units_next = {1'b0, st_q.units} + 1'b1;
        st_d = st_q;
        if (clr_i) begin
            st_d.units = '0;
        end else if (unit_i) begin
            st_d.units = units_next[CNT_W-1:0];
        end
    end

    assign expire_o = unit_i && (limit_i != '0) && (units_next >= {1'b0, limit_i});

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/rx_timeout_wdg.sv
module rx_timeout_wdg
    import rx_wdg_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned PRE_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_active_i,
    input  logic             bit_tick_i,
    input  logic             rssi_hit_i,
    input  logic             payload_rdy_i,
    input  logic [CNT_W-1:0] start_limit_i,
    input  logic [CNT_W-1:0] rssi_limit_i,
    input  logic             timeout_clr_i,
    output logic             timeout_o
);
    wdg_ctrl_t st_d, st_q;

    logic [CNT_W-1:0] limit_a  [NUM_PHASES];
    logic             cancel_a [NUM_PHASES];
    logic             count_en [NUM_PHASES];
    logic             unit_a   [NUM_PHASES];
    logic             expire_a [NUM_PHASES];
    logic             any_en;
    logic             wrap;
    logic             restart;

    assign limit_a[0]  = start_limit_i;
    assign limit_a[1]  = rssi_limit_i;
    assign cancel_a[0] = rssi_hit_i;
    assign cancel_a[1] = payload_rdy_i;

    assign any_en  = count_en[0] || count_en[1];
    assign restart = !rx_active_i || (st_d.phase != st_q.phase);

    rx_wdg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (restart),
        .tick_i (bit_tick_i && any_en),
        .wrap_o (wrap)
    );

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        localparam wdg_phase_e OWN_PH = (g == 0) ? PH_WAIT_RSSI : PH_WAIT_PAYLOAD;
        logic in_phase;

        assign in_phase    = (st_q.phase == OWN_PH);
        assign count_en[g] = rx_active_i && in_phase && !cancel_a[g] && (limit_a[g] != '0);
        assign unit_a[g]   = wrap && in_phase;

        rx_wdg_phase #(.CNT_W(CNT_W)) u_ph (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clr_i    (restart),
            .unit_i   (unit_a[g]),
            .limit_i  (limit_a[g]),
            .expire_o (expire_a[g])
        );
    end

    always_comb begin
        logic fire;
        fire = 1'b0;
        st_d = st_q;
        if (!rx_active_i) begin
            st_d.phase = PH_IDLE;
            st_d.flag  = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase = rssi_hit_i ? PH_WAIT_PAYLOAD : PH_WAIT_RSSI;
                end
                PH_WAIT_RSSI: begin
                    if (rssi_hit_i) begin
                        st_d.phase = PH_WAIT_PAYLOAD;
                    end else if (expire_a[0]) begin
                        st_d.phase = PH_DONE;
                        fire       = 1'b1;
                    end
                end
                PH_WAIT_PAYLOAD: begin
                    if (payload_rdy_i) begin
                        st_d.phase = PH_DONE;
                    end else if (expire_a[1]) begin
                        st_d.phase = PH_DONE;
                        fire       = 1'b1;
                    end
                end
                default: st_d.phase = PH_DONE;
            endcase
            st_d.flag = fire || (st_q.flag && !timeout_clr_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_IDLE, flag: 1'b0};
        else         st_q <= st_d;
    end

    assign timeout_o = st_q.flag;
endmodule

// File: rtl/rx_timeout_wdg_chk.sv
module rx_timeout_wdg_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rx_active_i,
    input logic             bit_tick_i,
    input logic [CNT_W-1:0] start_limit_i,
    input logic [CNT_W-1:0] rssi_limit_i,
    input logic             timeout_clr_i,
    input logic             timeout_o
);
    p_exit_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_active_i |=> !timeout_o);

    p_entry_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rx_active_i) |=> !timeout_o);

    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o && !timeout_clr_i && rx_active_i |=> timeout_o);

    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_clr_i && !bit_tick_i |=> !timeout_o);

    p_rise_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> ($past(bit_tick_i) && $past(rx_active_i)));

    p_zero_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_limit_i == '0) && (rssi_limit_i == '0) && !timeout_o |=> !timeout_o);
endmodule

bind rx_timeout_wdg rx_timeout_wdg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rx_active_i   (rx_active_i),
    .bit_tick_i    (bit_tick_i),
    .start_limit_i (start_limit_i),
    .rssi_limit_i  (rssi_limit_i),
    .timeout_clr_i (timeout_clr_i),
    .timeout_o     (timeout_o)
);

// File: tb/rx_timeout_wdg_tb.sv
`timescale 1ns/1ps
module rx_timeout_wdg_tb;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       rx_active = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rssi_hit = 1'b0;
    logic       payload_rdy = 1'b0;
    logic [7:0] start_limit = 8'd0;
    logic [7:0] rssi_limit = 8'd0;
    logic       tmo_clr = 1'b0;
    logic       timeout;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    int m_ph = 0;
    int m_t = 0;
    bit m_flag = 1'b0;

    always #10 clk = ~clk;

    rx_timeout_wdg u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .rx_active_i   (rx_active),
        .bit_tick_i    (bit_tick),
        .rssi_hit_i    (rssi_hit),
        .payload_rdy_i (payload_rdy),
        .start_limit_i (start_limit),
        .rssi_limit_i  (rssi_limit),
        .timeout_clr_i (tmo_clr),
        .timeout_o     (timeout)
    );

    task automatic chk(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: timeout_o actual=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference: counts ticks per phase, expiry at 16*limit ticks.
    task automatic model_edge();
        bit fire = 1'b0;
        if (!rx_active) begin
            m_ph = 0; m_t = 0; m_flag = 1'b0;
        end else begin
            case (m_ph)
                0: begin m_ph = rssi_hit ? 2 : 1; m_t = 0; end
                1: if (rssi_hit) begin
                        m_ph = 2; m_t = 0;
                    end else if (bit_tick && start_limit != 0) begin
                        m_t++;
                        if (m_t >= 16 * int'(start_limit)) begin m_ph = 3; fire = 1'b1; end
                    end
                2: if (payload_rdy) begin
                        m_ph = 3;
                    end else if (bit_tick && rssi_limit != 0) begin
                        m_t++;
                        if (m_t >= 16 * int'(rssi_limit)) begin m_ph = 3; fire = 1'b1; end
                    end
                default: ;
            endcase
            m_flag = fire | (m_flag & ~tmo_clr);
        end
    endtask

    task automatic step(bit rx, bit tk, bit rs, bit pl, bit cl);
        @(negedge clk);
        rx_active = rx; bit_tick = tk; rssi_hit = rs; payload_rdy = pl; tmo_clr = cl;
        model_edge();
        @(posedge clk);
        #1;
        chk(cur_tag, timeout, m_flag);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0);
    endtask

    task automatic session(int s, int r);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        start_limit = 8'(s); rssi_limit = 8'(r);
        step(1, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        #1;
        chk("R1", timeout, 1'b0);

        cur_tag = "R2";
        session(2, 0);
        ticks(31);
        chk("R2 before 32nd tick", timeout, 1'b0);
        ticks(1);
        chk("R2 at 32nd tick", timeout, 1'b1);
        ticks(10);

        cur_tag = "R10";
        session(1, 0);
        for (int i = 0; i < 80; i++) step(1, (i % 4) == 3, 0, 0, 0);
        chk("R10 after 20 sparse ticks", timeout, 1'b1);

        cur_tag = "R3";
        session(3, 1);
        ticks(20);
        step(1, 1, 1, 0, 0);
        cur_tag = "R4";
        ticks(15);
        chk("R4 before 16th tick", timeout, 1'b0);
        ticks(1);
        chk("R4 at 16th tick", timeout, 1'b1);

        cur_tag = "R3";
        session(1, 2);
        step(0, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0);
        ticks(31);
        chk("R3 entry event goes to phase two", timeout, 1'b0);
        ticks(1);
        chk("R3 phase two expiry", timeout, 1'b1);

        cur_tag = "R5";
        session(1, 2);
        step(1, 1, 0, 1, 0);
        ticks(10);
        step(1, 1, 1, 0, 0);
        ticks(10);
        step(1, 0, 0, 1, 0);
        ticks(60);
        chk("R5 payload cancels", timeout, 1'b0);

        cur_tag = "R6";
        session(0, 0);
        ticks(50);
        step(1, 1, 1, 0, 0);
        ticks(50);
        chk("R6 both disabled", timeout, 1'b0);
        session(0, 1);
        ticks(40);
        chk("R6 first phase disabled", timeout, 1'b0);

        cur_tag = "R7";
        session(1, 0);
        ticks(16);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);
        chk("R7 sticky", timeout, 1'b1);
        step(1, 0, 0, 0, 1);
        chk("R7 cleared", timeout, 1'b0);
        ticks(40);
        session(1, 0);
        ticks(15);
        step(1, 1, 0, 0, 1);
        chk("R7 set beats clear", timeout, 1'b1);

        cur_tag = "R8";
        step(0, 0, 0, 0, 0);
        chk("R8 exit clears", timeout, 1'b0);
        session(2, 0);
        ticks(20);
        step(0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        ticks(31);
        chk("R8 no carry-over", timeout, 1'b0);
        ticks(1);
        chk("R8 fresh count", timeout, 1'b1);

        cur_tag = "R9";
        session(2, 1);
        ticks(31);
        step(1, 1, 1, 0, 0);
        chk("R9 threshold on final tick", timeout, 1'b0);
        ticks(15);
        step(1, 1, 0, 1, 0);
        chk("R9 payload on final tick", timeout, 1'b0);
        ticks(40);

        cur_tag = "RND R4";
        for (int s = 0; s < 60; s++) begin
            session($urandom_range(0, 3), $urandom_range(0, 3));
            for (int c = 0; c < int'($urandom_range(20, 180)); c++)
                step(1, $urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0,
                     $urandom_range(0, 30) == 0, $urandom_range(0, 40) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule